// File: doc/BRIEF.md
# Descriptor-Chain Memory Read Engine

This block is the read half of a memory-to-memory copy engine. Software builds a linked list of three-word descriptors in memory. Each descriptor holds a control word, a buffer pointer and a pointer to the next descriptor. The engine walks this list and reads each buffer one word at a time. It emits the bytes one at a time on a valid/ready stream, and a last flag marks the end of a frame. The stream feeds the write half of the copy engine.

Ownership passes between software and the engine through the top bit of each control word. With the owner check on, a descriptor still held by software stops the walk and raises a descriptor-error pulse. With write-back on, the engine hands each finished descriptor back to software by rewriting its control word with the owner bit cleared. Three pulse commands drive the engine:
- Start loads the base address and begins the walk.
- Stop halts the walk cleanly.
- Restart resumes at the descriptor the engine is currently positioned on. After an owner-check stop, software can set the owner bit and restart without rebuilding the list.

Single-cycle pulses report each finished descriptor, each end-of-frame descriptor, each owner-check failure, and the end of a whole list. The address of the most recent end-of-frame descriptor is held on an output.

Top module: `dchain_rd_eng`

## Requirements
- R1: After reset the engine is idle. It makes no memory request, its stream output is not valid, all event pulses are low, and the end-of-frame address reads zero.
- R2: A start pulse while idle reads the control word at the base address, then the buffer pointer at base+4, then the next pointer at base+8, and then the buffer. Each request holds its address until it is acknowledged.
- R3: A descriptor emits exactly as many bytes as control bits [23:12] give. The bytes come little-endian within each word, in ascending word order from the buffer pointer with its two low bits forced to zero. Bytes beyond the count in the final word are dropped, and a count of zero emits nothing.
- R4: The last flag is asserted on the final byte of a descriptor only when control bit 30 (end of frame) is set. It is asserted on no other byte.
- R5: With the owner check on, a control word whose bit 31 is 0 emits no bytes and writes nothing. It raises a one-cycle descriptor-error pulse and returns the engine to idle. With the check off, such a descriptor is processed normally.
- R6: With write-back on, each finished descriptor gets one write to its own address, carrying the original control word with bit 31 cleared. With write-back off, nothing is written.
- R7: Finishing a descriptor with bit 30 set latches that descriptor's address on the end-of-frame output and pulses the frame event. If its next pointer is also zero, it pulses the list-end event too.
- R8: Every descriptor that completes produces exactly one done pulse.
- R9: A zero next pointer ends the walk, and the engine goes idle. Any other value is fetched next, including a pointer back to an earlier descriptor, so a circular list keeps running until it meets a descriptor the owner check rejects.
- R10: A restart pulse while idle re-fetches the control word of the current descriptor: the one that failed the owner check or was stopped. After a list that ended on a zero pointer, a restart does nothing.
- R11: A stop pulse lets an outstanding memory access complete, then returns the engine to idle. It writes no owner bit back and raises no event. With no access outstanding, the engine goes idle on the next cycle.
- R12: While the stream output is valid and not accepted, its data and last flag hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | ADDR_W | Address of the first descriptor, loaded by start |
| cfg_owner_chk | input | 1 | Enable the owner-bit check |
| cfg_auto_wb | input | 1 | Enable write-back of the cleared owner bit |
| cmd_start | input | 1 | One-cycle start command |
| cmd_stop | input | 1 | One-cycle stop command |
| cmd_restart | input | 1 | One-cycle restart command |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Stream byte valid |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of a frame |
| out_ready | input | 1 | Stream sink accepts the byte |
| busy | output | 1 | Engine is not idle |
| eof_desc_addr | output | ADDR_W | Address of the last end-of-frame descriptor |
| evt_done | output | 1 | Descriptor finished pulse |
| evt_eof | output | 1 | End-of-frame descriptor finished pulse |
| evt_dscr_err | output | 1 | Owner-check failure pulse |
| evt_total_eof | output | 1 | End of list pulse |

## Verification
The bench builds the engine with ADDR_W at 16. Every descriptor and buffer then fits in a 4 KiB model memory, and a 32-bit next-pointer word is cut down to the address width. It places descriptors at chosen addresses, including an unaligned buffer pointer and a two-entry circular list. It throttles the stream sink to exercise the hold-while-stalled path and the word-to-word refill. It issues stop both while a control-word fetch is outstanding and while the byte stream is stalled, and follows each stop with a restart.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int LEN_W    = 12;
    localparam int LEN_LSB  = 12;
    localparam int BIT_EOF  = 30;
    localparam int BIT_OWN  = 31;
    localparam logic [WORD_W-1:0] OWN_MASK = WORD_W'(1) << BIT_OWN;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CTL,
        S_BUF,
        S_NXT,
        S_DATA,
        S_PUSH,
        S_WB
    } eng_st_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             eof;
    } ctl_f_t;

endpackage

// File: rtl/dchain_ctl_dec.sv
module dchain_ctl_dec
    import dchain_pkg::*;
(
    input  logic [WORD_W-1:0] ctl_word,
    output ctl_f_t            fields
);

    always_comb begin
        fields.len = ctl_word[LEN_LSB +: LEN_W];
        fields.eof = ctl_word[BIT_EOF];
    end

endmodule

// File: rtl/dchain_byte_pick.sv
module dchain_byte_pick #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic [WORD_W-1:0]                  word_i,
    input  logic [$clog2(WORD_W/BYTE_W)-1:0]   idx_i,
    output logic [BYTE_W-1:0]                  byte_o
);

    localparam int LANES = WORD_W / BYTE_W;

    logic [BYTE_W-1:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word_i[g*BYTE_W +: BYTE_W];
    end

    assign byte_o = lane[idx_i];

endmodule

// File: rtl/dchain_rd_eng.sv
module dchain_rd_eng
    import dchain_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              cfg_owner_chk,
    input  logic              cfg_auto_wb,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_restart,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_last,
    input  logic              out_ready,
    output logic              busy,
    output logic [ADDR_W-1:0] eof_desc_addr,
    output logic              evt_done,
    output logic              evt_eof,
    output logic              evt_dscr_err,
    output logic              evt_total_eof
);

    localparam int LANES = WORD_W / BYTE_W;
    localparam int IDX_W = $clog2(LANES);
    localparam logic [ADDR_W-1:0] OFS_BUF = ADDR_W'(LANES);
    localparam logic [ADDR_W-1:0] OFS_NXT = ADDR_W'(2 * LANES);
    localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(LANES);
    localparam logic [ADDR_W-1:0] ALIGN_M = ADDR_W'(LANES - 1);

    typedef struct packed {
        eng_st_e           st;
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] bptr;
        logic [ADDR_W-1:0] nxt;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] eof_addr;
        logic [WORD_W-1:0] ctl;
        logic [WORD_W-1:0] word;
        logic [WORD_W-1:0] wdata;
        logic [LEN_W-1:0]  rem;
        logic [IDX_W-1:0]  bidx;
        logic              req;
        logic              we;
        logic              ov;
        logic              stop_pend;
        logic              e_done;
        logic              e_eof;
        logic              e_err;
        logic              e_tot;
    } state_t;

    state_t q, d;
    ctl_f_t cf;
    logic   ack_hit, halt, finish, complete, abort;

    dchain_ctl_dec u_ctl_dec (
        .ctl_word (q.ctl),
        .fields   (cf)
    );

    dchain_byte_pick #(
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W)
    ) u_byte_pick (
        .word_i (q.word),
        .idx_i  (q.bidx),
        .byte_o (out_data)
    );

    always_comb begin
        d          = q;
        d.e_done   = 1'b0;
        d.e_eof    = 1'b0;
        d.e_err    = 1'b0;
        d.e_tot    = 1'b0;
        ack_hit    = q.req & mem_ack;
        halt       = q.stop_pend | cmd_stop;
        finish     = 1'b0;
        complete   = 1'b0;
        abort      = 1'b0;

        if (ack_hit) d.req = 1'b0;
        if (q.req && !mem_ack && cmd_stop) d.stop_pend = 1'b1;

        unique case (q.st)
            S_IDLE: begin
                if (cmd_start) begin
                    d.cur       = cfg_base;
                    d.req       = 1'b1;
                    d.we        = 1'b0;
                    d.addr      = cfg_base;
                    d.stop_pend = 1'b0;
                    d.st        = S_CTL;
                end else if (cmd_restart && q.cur != '0) begin
                    d.req  = 1'b1;
                    d.we   = 1'b0;
                    d.addr = q.cur;
                    d.st   = S_CTL;
                end
            end
            S_CTL: begin
                if (ack_hit) begin
                    if (halt) begin
                        abort = 1'b1;
                    end else begin
                        d.ctl = mem_rdata;
                        if (cfg_owner_chk && !mem_rdata[BIT_OWN]) begin
                            d.e_err = 1'b1;
                            d.st    = S_IDLE;
                        end else begin
                            d.req  = 1'b1;
                            d.we   = 1'b0;
                            d.addr = q.cur + OFS_BUF;
                            d.st   = S_BUF;
                        end
                    end
                end
            end
            S_BUF: begin
                if (ack_hit) begin
                    if (halt) begin
                        abort = 1'b1;
                    end else begin
                        d.bptr = mem_rdata[ADDR_W-1:0] & ~ALIGN_M;
                        d.req  = 1'b1;
                        d.we   = 1'b0;
                        d.addr = q.cur + OFS_NXT;
                        d.st   = S_NXT;
                    end
                end
            end
            S_NXT: begin
                if (ack_hit) begin
                    if (halt) begin
                        abort = 1'b1;
                    end else begin
                        d.nxt = mem_rdata[ADDR_W-1:0];
                        d.rem = cf.len;
                        if (cf.len == '0) begin
                            finish = 1'b1;
                        end else begin
                            d.req  = 1'b1;
                            d.we   = 1'b0;
                            d.addr = q.bptr;
                            d.st   = S_DATA;
                        end
                    end
                end
            end
            S_DATA: begin
                if (ack_hit) begin
                    if (halt) begin
                        abort = 1'b1;
                    end else begin
                        d.word = mem_rdata;
                        d.bidx = '0;
                        d.bptr = q.bptr + STEP;
                        d.ov   = 1'b1;
                        d.st   = S_PUSH;
                    end
                end
            end
            S_PUSH: begin
                if (cmd_stop) begin
                    abort = 1'b1;
                end else if (out_ready) begin
                    d.rem = q.rem - LEN_W'(1);
                    if (q.rem == LEN_W'(1)) begin
                        d.ov   = 1'b0;
                        finish = 1'b1;
                    end else if (q.bidx == IDX_W'(LANES - 1)) begin
                        d.ov   = 1'b0;
                        d.req  = 1'b1;
                        d.we   = 1'b0;
                        d.addr = q.bptr;
                        d.st   = S_DATA;
                    end else begin
                        d.bidx = q.bidx + IDX_W'(1);
                    end
                end
            end
            S_WB: begin
                if (ack_hit) begin
                    if (halt) abort = 1'b1;
                    else      complete = 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (finish) begin
            if (cfg_auto_wb) begin
                d.req   = 1'b1;
                d.we    = 1'b1;
                d.addr  = q.cur;
                d.wdata = q.ctl & ~OWN_MASK;
                d.st    = S_WB;
            end else begin
                complete = 1'b1;
            end
        end

        if (complete) begin
            d.e_done = 1'b1;
            if (cf.eof) begin
                d.eof_addr = q.cur;
                d.e_eof    = 1'b1;
                d.e_tot    = (d.nxt == '0);
            end
            d.cur = d.nxt;
            if (d.nxt == '0) begin
                d.st = S_IDLE;
            end else begin
                d.req  = 1'b1;
                d.we   = 1'b0;
                d.addr = d.nxt;
                d.st   = S_CTL;
            end
        end

        if (abort) begin
            d.st        = S_IDLE;
            d.req       = 1'b0;
            d.ov        = 1'b0;
            d.stop_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_req       = q.req;
    assign mem_we        = q.we;
    assign mem_addr      = q.addr;
    assign mem_wdata     = q.wdata;
    assign out_valid     = q.ov;
    assign out_last      = q.ov && cf.eof && (q.rem == LEN_W'(1));
    assign busy          = (q.st != S_IDLE);
    assign eof_desc_addr = q.eof_addr;
    assign evt_done      = q.e_done;
    assign evt_eof       = q.e_eof;
    assign evt_dscr_err  = q.e_err;
    assign evt_total_eof = q.e_tot;

    // R2: a request keeps its address and direction until acknowledged
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R12: a stalled stream byte does not change
    a_r12_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !cmd_stop |=> out_valid && $stable(out_data) && $stable(out_last));

    // R6: every write hands the descriptor back to software
    a_r6_wb_clears_owner: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[BIT_OWN]);

    // R7: list end only comes with a frame end
    a_r7_total_needs_eof: assert property (@(posedge clk) disable iff (!rst_n)
        evt_total_eof |-> evt_eof);

    // R8: frame end only comes with a finished descriptor
    a_r8_eof_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        evt_eof |-> evt_done);

    // R5: a rejected descriptor never also completes
    a_r5_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        evt_dscr_err |-> !evt_done && !out_valid);

    // R11: stop with nothing outstanding idles at once
    a_r11_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop && busy && !mem_req |=> !busy);

    // R1: an idle engine is quiet on both sides
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !out_valid);

endmodule

// File: tb/dchain_rd_eng_tb_top.sv
module dchain_rd_eng_tb_top;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic          cfg_owner_chk = 1'b1;
    logic          cfg_auto_wb = 1'b1;
    logic          cmd_start = 1'b0;
    logic          cmd_stop = 1'b0;
    logic          cmd_restart = 1'b0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_ack = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          out_valid, out_last;
    logic [7:0]    out_data;
    logic          out_ready = 1'b1;
    logic          busy;
    logic [AW-1:0] eof_desc_addr;
    logic          evt_done, evt_eof, evt_dscr_err, evt_total_eof;

    always #5 clk = ~clk;

    dchain_rd_eng #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base),
        .cfg_owner_chk(cfg_owner_chk), .cfg_auto_wb(cfg_auto_wb),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_restart(cmd_restart),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready), .busy(busy), .eof_desc_addr(eof_desc_addr),
        .evt_done(evt_done), .evt_eof(evt_eof), .evt_dscr_err(evt_dscr_err),
        .evt_total_eof(evt_total_eof)
    );

    // memory model: one writer for the array
    logic [31:0] mem [0:1023];
    logic        ld_en = 1'b0;
    logic [9:0]  ld_idx = '0;
    logic [31:0] ld_val = '0;

    always @(posedge clk) begin
        if (ld_en) mem[ld_idx] <= ld_val;
        if (mem_req && !mem_ack) begin
            mem_rdata <= mem[mem_addr[11:2]];
            if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        end
        mem_ack <= mem_req && !mem_ack;
    end

    // sink readiness: 0 always, 1 pseudo-random, 2 never
    int          rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    always @(posedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0:       out_ready <= 1'b1;
            1:       out_ready <= lfsr[0];
            default: out_ready <= 1'b0;
        endcase
    end

    // monitor, sampled between edges; counters only grow
    logic [7:0]    got_b [0:255];
    logic          got_l [0:255];
    logic [AW-1:0] rd_a  [0:255];
    int nb = 0, nrd = 0, nwr = 0, n_last = 0;
    int n_done = 0, n_eof = 0, n_err = 0, n_tot = 0;

    always @(negedge clk) begin
        if (out_valid && out_ready) begin
            got_b[nb[7:0]] = out_data;
            got_l[nb[7:0]] = out_last;
            nb++;
            if (out_last) n_last++;
        end
        if (mem_req && mem_ack) begin
            if (mem_we) nwr++;
            else begin
                rd_a[nrd[7:0]] = mem_addr;
                nrd++;
            end
        end
        if (evt_done) n_done++;
        if (evt_eof) n_eof++;
        if (evt_dscr_err) n_err++;
        if (evt_total_eof) n_tot++;
    end

    int vec = 0;
    int fails = 0;
    int b0, r0, w0, l0, dn0, e0, er0, t0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctl(input bit own, input bit eof, input int len);
        logic [11:0] l;
        l = len[11:0];
        return {own, eof, 1'b0, 1'b0, 4'b0, l, l};
    endfunction

    task automatic poke(input logic [AW-1:0] a, input logic [31:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = a[11:2]; ld_val = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic put_desc(input logic [AW-1:0] a, input logic [31:0] c,
                            input logic [AW-1:0] b, input logic [AW-1:0] n);
        poke(a, c);
        poke(a + 16'd4, {16'h0, b});
        poke(a + 16'd8, {16'h0, n});
    endtask

    task automatic mark();
        b0 = nb; r0 = nrd; w0 = nwr; l0 = n_last;
        dn0 = n_done; e0 = n_eof; er0 = n_err; t0 = n_tot;
    endtask

    task automatic go_start(input logic [AW-1:0] base);
        @(negedge clk);
        cfg_base = base; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic go_restart();
        @(negedge clk); cmd_restart = 1'b1;
        @(negedge clk); cmd_restart = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk); @(negedge clk);
        for (int i = 0; i < 3000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 busy", {31'b0, busy}, 0);
        chk("R1 mem_req", {31'b0, mem_req}, 0);
        chk("R1 out_valid", {31'b0, out_valid}, 0);
        chk("R1 eof addr", {16'b0, eof_desc_addr}, 0);
        chk("R1 events", {28'b0, evt_done, evt_eof, evt_dscr_err, evt_total_eof}, 0);
    endtask

    task automatic t_single();
        logic [7:0] exp_b [6];
        exp_b = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
        cfg_owner_chk = 1'b1; cfg_auto_wb = 1'b1; rdy_mode = 0;
        put_desc(16'h100, mk_ctl(1, 1, 6), 16'h400, 16'h0);
        poke(16'h400, 32'h44332211);
        poke(16'h404, 32'h88776655);
        mark();
        go_start(16'h100);
        wait_idle();
        chk("R2 fetch ctl", {16'b0, rd_a[r0[7:0]]}, 32'h100);
        chk("R2 fetch buf", {16'b0, rd_a[(r0 + 1) & 255]}, 32'h104);
        chk("R2 fetch next", {16'b0, rd_a[(r0 + 2) & 255]}, 32'h108);
        chk("R2 fetch data", {16'b0, rd_a[(r0 + 3) & 255]}, 32'h400);
        chk("R3 byte count", nb - b0, 6);
        for (int i = 0; i < 6; i++) chk("R3 byte", {24'b0, got_b[(b0 + i) & 255]}, {24'b0, exp_b[i]});
        chk("R4 last on final", {31'b0, got_l[(b0 + 5) & 255]}, 1);
        chk("R4 single last", n_last - l0, 1);
        chk("R6 one write", nwr - w0, 1);
        chk("R6 owner cleared", mem[16'h100 >> 2], 32'h40006006);
        chk("R7 eof addr", {16'b0, eof_desc_addr}, 32'h100);
        chk("R7 eof event", n_eof - e0, 1);
        chk("R7 total event", n_tot - t0, 1);
        chk("R8 done", n_done - dn0, 1);
        chk("R9 idle", {31'b0, busy}, 0);
    endtask

    task automatic t_chain_bp();
        logic [7:0] exp_b [8];
        exp_b = '{8'hA0, 8'hA1, 8'hA2, 8'hB0, 8'hB1, 8'hB2, 8'hB3, 8'hB4};
        rdy_mode = 1;
        put_desc(16'h200, mk_ctl(1, 0, 3), 16'h500, 16'h240);
        put_desc(16'h240, mk_ctl(1, 1, 5), 16'h602, 16'h0);
        poke(16'h500, 32'hA3A2A1A0);
        poke(16'h600, 32'hB3B2B1B0);
        poke(16'h604, 32'hB7B6B5B4);
        mark();
        go_start(16'h200);
        wait_idle();
        rdy_mode = 0;
        chk("R9 chained bytes", nb - b0, 8);
        for (int i = 0; i < 8; i++) chk("R3 chained byte", {24'b0, got_b[(b0 + i) & 255]}, {24'b0, exp_b[i]});
        chk("R4 no last mid-chain", {31'b0, got_l[(b0 + 2) & 255]}, 0);
        chk("R4 last at end", {31'b0, got_l[(b0 + 7) & 255]}, 1);
        chk("R8 two done", n_done - dn0, 2);
        chk("R7 one eof", n_eof - e0, 1);
        chk("R7 eof addr second", {16'b0, eof_desc_addr}, 32'h240);
    endtask

    task automatic t_owner_block();
        cfg_owner_chk = 1'b1; cfg_auto_wb = 1'b1;
        put_desc(16'h300, mk_ctl(0, 1, 2), 16'h700, 16'h0);
        poke(16'h700, 32'h0000BBAA);
        mark();
        go_start(16'h300);
        wait_idle();
        chk("R5 error pulse", n_err - er0, 1);
        chk("R5 no bytes", nb - b0, 0);
        chk("R5 no write", nwr - w0, 0);
        chk("R5 no done", n_done - dn0, 0);
        poke(16'h300, mk_ctl(1, 1, 2));
        mark();
        go_restart();
        wait_idle();
        chk("R10 restart bytes", nb - b0, 2);
        chk("R10 restart byte0", {24'b0, got_b[b0[7:0]]}, 32'hAA);
        chk("R10 restart done", n_done - dn0, 1);
        chk("R10 restart fetch", {16'b0, rd_a[r0[7:0]]}, 32'h300);
    endtask

    task automatic t_no_check();
        cfg_owner_chk = 1'b0; cfg_auto_wb = 1'b0;
        put_desc(16'h340, mk_ctl(0, 1, 1), 16'h700, 16'h0);
        mark();
        go_start(16'h340);
        wait_idle();
        chk("R5 unchecked processed", nb - b0, 1);
        chk("R5 unchecked no err", n_err - er0, 0);
        chk("R6 no write when off", nwr - w0, 0);
        chk("R6 ctl untouched", mem[16'h340 >> 2], mk_ctl(0, 1, 1));
        mark();
        go_restart();
        wait_idle();
        chk("R10 restart after list end", nrd - r0, 0);
        cfg_owner_chk = 1'b1; cfg_auto_wb = 1'b1;
    endtask

    task automatic t_zero_and_noeof();
        put_desc(16'h380, mk_ctl(1, 1, 0), 16'h700, 16'h0);
        mark();
        go_start(16'h380);
        wait_idle();
        chk("R3 zero length no bytes", nb - b0, 0);
        chk("R7 zero length eof", n_eof - e0, 1);
        chk("R7 zero length total", n_tot - t0, 1);
        chk("R7 zero length addr", {16'b0, eof_desc_addr}, 32'h380);
        put_desc(16'h3C0, mk_ctl(1, 0, 2), 16'h700, 16'h0);
        mark();
        go_start(16'h3C0);
        wait_idle();
        chk("R4 no eof bytes", nb - b0, 2);
        chk("R4 no eof no last", n_last - l0, 0);
        chk("R7 no eof no event", n_eof - e0, 0);
        chk("R7 no eof no total", n_tot - t0, 0);
        chk("R7 eof addr kept", {16'b0, eof_desc_addr}, 32'h380);
    endtask

    task automatic t_circular();
        put_desc(16'h800, mk_ctl(1, 0, 1), 16'h700, 16'h840);
        put_desc(16'h840, mk_ctl(1, 1, 2), 16'h700, 16'h800);
        mark();
        go_start(16'h800);
        wait_idle();
        chk("R9 circular bytes", nb - b0, 3);
        chk("R9 circular done", n_done - dn0, 2);
        chk("R9 circular ends on owner", n_err - er0, 1);
        chk("R9 circular no total", n_tot - t0, 0);
        chk("R6 circular writes", nwr - w0, 2);
        chk("R6 first cleared", mem[16'h800 >> 2], mk_ctl(0, 0, 1));
        chk("R6 second cleared", mem[16'h840 >> 2], mk_ctl(0, 1, 2));
    endtask

    task automatic t_stop_stream();
        put_desc(16'h900, mk_ctl(1, 1, 40), 16'hA00, 16'h0);
        rdy_mode = 2;
        mark();
        go_start(16'h900);
        for (int i = 0; i < 100; i++) begin
            if (out_valid) break;
            @(negedge clk);
        end
        @(negedge clk); cmd_stop = 1'b1;
        @(negedge clk); cmd_stop = 1'b0;
        chk("R11 idle after stop", {31'b0, busy}, 0);
        wait_idle();
        chk("R11 no bytes", nb - b0, 0);
        chk("R11 no write", nwr - w0, 0);
        chk("R11 no done", n_done - dn0, 0);
        chk("R11 owner kept", mem[16'h900 >> 2], mk_ctl(1, 1, 40));
        rdy_mode = 0;
        mark();
        go_restart();
        wait_idle();
        chk("R10 resume after stop", nb - b0, 40);
        chk("R4 long frame one last", n_last - l0, 1);
    endtask

    task automatic t_stop_inflight();
        poke(16'h900, mk_ctl(1, 1, 40));
        mark();
        @(negedge clk);
        cfg_base = 16'h900; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0; cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        wait_idle();
        chk("R11 inflight read completes", nrd - r0, 1);
        chk("R11 inflight no bytes", nb - b0, 0);
        chk("R11 inflight no done", n_done - dn0, 0);
        chk("R11 inflight idle", {31'b0, busy}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_single();
        t_chain_bp();
        t_owner_block();
        t_no_check();
        t_zero_and_noeof();
        t_circular();
        t_stop_stream();
        t_stop_inflight();
        $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec + 1, fails + 1);
        $finish;
    end

endmodule